// File: doc/BRIEF.md
# Paper-Tape Binary Block Loader

This block turns a byte stream from a tape reader into memory writes. The stream holds one or more records, with runs of zero bytes between them. Each record is a word count, one pad byte, a 16-bit load address, the data words and a 16-bit checksum. The loader writes each data word through a one-cycle write strobe to consecutive addresses. It ends with a done flag and a status code: success, format error or checksum error.

Software or a boot sequencer pulses `start_i` and then feeds bytes through a valid/ready handshake. `eos_i` marks the end of the stream. `mem_size_i` gives the installed memory size, and the loader suppresses writes at or above that size. After `done_o` rises, the block refuses further bytes until the next start pulse or reset.

Top module: `tape_loader`

## Requirements
- R1: While searching for a record, zero bytes are skipped. The first nonzero byte is the data word count (1 to 255). The next byte is discarded whatever its value.
- R2: The load address and each data word are two bytes, high byte first. Data words are written to the load address, then to the load address plus one, and so on. Each completed word gives exactly one `wr_en_o` pulse, in the cycle after its low byte is consumed.
- R3: The checksum is the 16-bit load address plus every data word, taken modulo 65536, and excludes the count and pad bytes. If the trailing checksum word matches, the loader searches for the next record. If it does not match, `done_o` rises with `status_o` = 2.
- R4: After at least one record has loaded, the tenth consecutive zero byte ends the load with `done_o` and `status_o` = 0. A shorter zero run followed by a nonzero byte starts a new record. Before the first record, zero runs of any length are accepted.
- R5: `eos_i` high with `valid_i` low while searching between records ends the load with `status_o` = 0.
- R6: `eos_i` high with `valid_i` low anywhere inside a record (pad, address, data or checksum) ends the load with `status_o` = 1.
- R7: A data word whose address is not below `mem_size_i` produces no write. It still enters the checksum and still advances the address.
- R8: While `done_o` is high, `ready_o` is low, no write occurs, and `done_o` and `status_o` hold until reset. A `start_i` pulse clears `done_o` and `status_o` and begins a fresh search in which no record counts as loaded.
- R9: After reset, `ready_o`, `done_o` and `wr_en_o` are low and `status_o` is 0, and bytes are refused until `start_i`.
- R10: A byte is consumed only in a cycle with both `valid_i` and `ready_o` high. Idle cycles with `valid_i` low change nothing.
- R11: The write address wraps from 2^AW-1 to 0, and the checksum wraps modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new load |
| byte_i | input | 8 | Stream byte |
| valid_i | input | 1 | `byte_i` is valid |
| eos_i | input | 1 | Stream has ended (meaningful when `valid_i` is low) |
| mem_size_i | input | AW+1 | Installed memory size in words |
| ready_o | output | 1 | Loader accepts a byte this cycle |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | AW | Memory write address |
| wr_data_o | output | 16 | Memory write data |
| done_o | output | 1 | Load finished |
| status_o | output | 2 | 0 success, 1 format error, 2 checksum error |

## Verification
The hardest situation to reach is a suppressed write whose effect shows up later. A skipped word leaves no trace at the ports unless a later word of the same record lands at an observable address. The stimulus therefore starts a record just below the top of the address space, with a small memory size. The first two words are dropped, and the third wraps to address zero and is written there, with a checksum covering all three. End of stream cut inside a record and a corrupted checksum are driven separately. The bench then offers bytes after done to show they are refused.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_SEEK, S_PAD, S_AHI, S_ALO, S_DHI, S_DLO, S_KHI, S_KLO, S_DONE
  } ld_state_e;

  typedef enum logic [1:0] {
    LD_OK  = 2'd0,
    LD_FMT = 2'd1,
    LD_SUM = 2'd2
  } ld_status_e;
endpackage

// File: rtl/tl_pair.sv
module tl_pair #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_hi_i,
  input  logic [BW-1:0] byte_i,
  output logic [2*BW-1:0] word_o
);
  logic [BW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_q <= '0;
    else if (cap_hi_i) hi_q <= byte_i;
  end

  assign word_o = {hi_q, byte_i};
endmodule

// File: rtl/tl_csum.sv
module tl_csum #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          seed_i,
  input  logic          add_i,
  input  logic [CW-1:0] val_i,
  output logic [CW-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_o <= '0;
    else if (seed_i) sum_o <= val_i;
    else if (add_i)  sum_o <= sum_o + val_i;
  end

  // R11
  sum_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i && !seed_i |=> sum_o == CW'($past(sum_o) + $past(val_i)));
  // R3
  sum_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_i |=> sum_o == $past(val_i));
endmodule

// File: rtl/tl_addr.sv
module tl_addr #(
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic [AW:0]   mem_size_i,
  output logic [AW-1:0] addr_o,
  output logic          in_range_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= '0;
    else if (load_i)  addr_o <= load_val_i;
    else if (step_i)  addr_o <= addr_o + AW'(1);
  end

  assign in_range_o = {1'b0, addr_o} < mem_size_i;

  // R11
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> addr_o == AW'($past(addr_o) + AW'(1)));
endmodule

// File: rtl/tape_loader.sv
module tape_loader
  import tl_pkg::*;
#(
  parameter int AW       = 15,
  parameter int ZERO_RUN = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        byte_i,
  input  logic              valid_i,
  input  logic              eos_i,
  input  logic [AW:0]       mem_size_i,
  output logic              ready_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic [1:0]        status_o
);
  localparam int ZW = $clog2(ZERO_RUN + 1);

  ld_state_e         state_q;
  logic [7:0]        cnt_q;
  logic [ZW-1:0]     zcnt_q;
  logic              loaded_q;
  logic              fire, eos_hit;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] sum;
  logic [AW-1:0]     addr;
  logic              in_range;

  assign ready_o = (state_q != S_IDLE) && (state_q != S_DONE);
  assign fire    = valid_i && ready_o;
  assign eos_hit = eos_i && !valid_i && ready_o;

  tl_pair #(.BW(8)) u_pair (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_hi_i (fire && (state_q == S_AHI || state_q == S_DHI || state_q == S_KHI)),
    .byte_i   (byte_i),
    .word_o   (word)
  );

  tl_csum #(.CW(WORD_W)) u_csum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (fire && state_q == S_ALO),
    .add_i  (fire && state_q == S_DLO),
    .val_i  (word),
    .sum_o  (sum)
  );

  tl_addr #(.AW(AW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fire && state_q == S_ALO),
    .load_val_i (word[AW-1:0]),
    .step_i     (fire && state_q == S_DLO),
    .mem_size_i (mem_size_i),
    .addr_o     (addr),
    .in_range_o (in_range)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      zcnt_q    <= '0;
      loaded_q  <= 1'b0;
      done_o    <= 1'b0;
      status_o  <= LD_OK;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q  <= S_SEEK;
        zcnt_q   <= '0;
        loaded_q <= 1'b0;
        done_o   <= 1'b0;
        status_o <= LD_OK;
      end else begin
        unique case (state_q)
          S_SEEK: begin
            if (eos_hit) begin
              state_q <= S_DONE;
              done_o  <= 1'b1;
            end else if (fire) begin
              if (byte_i != 8'd0) begin
                cnt_q   <= byte_i;
                zcnt_q  <= '0;
                state_q <= S_PAD;
              end else if (loaded_q) begin
                if (zcnt_q == ZW'(ZERO_RUN - 1)) begin
                  state_q <= S_DONE;
                  done_o  <= 1'b1;
                end else begin
                  zcnt_q <= zcnt_q + ZW'(1);
                end
              end
            end
          end
          S_PAD, S_AHI, S_ALO, S_DHI, S_DLO, S_KHI, S_KLO: begin
            if (eos_hit) begin
              state_q  <= S_DONE;
              done_o   <= 1'b1;
              status_o <= LD_FMT;
            end else if (fire) begin
              unique case (state_q)
                S_PAD: state_q <= S_AHI;
                S_AHI: state_q <= S_ALO;
                S_ALO: state_q <= S_DHI;
                S_DHI: state_q <= S_DLO;
                S_DLO: begin
                  wr_en_o   <= in_range;
                  wr_addr_o <= addr;
                  wr_data_o <= word;
                  cnt_q     <= cnt_q - 8'd1;
                  state_q   <= (cnt_q == 8'd1) ? S_KHI : S_DHI;
                end
                S_KHI: state_q <= S_KLO;
                default: begin
                  if (word == sum) begin
                    loaded_q <= 1'b1;
                    state_q  <= S_SEEK;
                  end else begin
                    state_q  <= S_DONE;
                    done_o   <= 1'b1;
                    status_o <= LD_SUM;
                  end
                end
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  done_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o && !wr_en_o);
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(status_o));
  // R7
  wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ({1'b0, wr_addr_o} < $past(mem_size_i)));
  // R10
  wr_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(valid_i && ready_o));
  // R2
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  // R9
  status_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != LD_OK |-> done_o);
endmodule

// File: tb/tape_loader_bench.sv
`timescale 1ns/1ps
module tape_loader_bench;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [7:0]    byte_i = 8'd0;
  logic          valid_i = 1'b0;
  logic          eos_i = 1'b0;
  logic [AW:0]   mem_size_i = 16'h8000;
  logic          ready_o, wr_en_o, done_o;
  logic [AW-1:0] wr_addr_o;
  logic [15:0]   wr_data_o;
  logic [1:0]    status_o;

  int total = 0;
  int bad = 0;

  logic [AW-1:0] wl_a [64];
  logic [15:0]   wl_d [64];
  int            wcnt = 0;
  logic [15:0]   dw [8];

  always #2.5 clk = ~clk;

  tape_loader #(.AW(AW)) u_tape_loader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .byte_i(byte_i),
    .valid_i(valid_i), .eos_i(eos_i), .mem_size_i(mem_size_i),
    .ready_o(ready_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .done_o(done_o), .status_o(status_o)
  );

  always @(negedge clk) begin
    if (wr_en_o) begin
      if (wcnt < 64) begin
        wl_a[wcnt] = wr_addr_o;
        wl_d[wcnt] = wr_data_o;
      end
      wcnt = wcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    wcnt = 0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    byte_i = b;
    valid_i = 1'b1;
    for (int n = 0; n < 50 && !ready_o; n++) @(negedge clk);
    @(negedge clk) valid_i = 1'b0;
  endtask

  task automatic put_word(input logic [15:0] w);
    put(w[15:8]);
    put(w[7:0]);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) put(8'h00);
  endtask

  task automatic send_rec(input int n, input logic [7:0] pad, input logic [15:0] ld, input logic [15:0] twist);
    logic [15:0] s;
    s = ld;
    put(8'(n));
    put(pad);
    put_word(ld);
    for (int i = 0; i < n; i++) begin
      put_word(dw[i]);
      s = s + dw[i];
    end
    put_word(s ^ twist);
  endtask

  task automatic wait_done();
    for (int n = 0; n < 200 && !done_o; n++) @(negedge clk);
  endtask

  task automatic end_stream();
    @(negedge clk) eos_i = 1'b1;
    wait_done();
    @(negedge clk) eos_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 ready", ready_o, 0);
    chk("R9 done", done_o, 0);
    chk("R9 wr_en", wr_en_o, 0);
    chk("R9 status", status_o, 0);
    // bytes before start are refused
    byte_i = 8'h03; valid_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 refuse", ready_o, 0);
    chk("R10 no write", wcnt, 0);
    valid_i = 1'b0;
  endtask

  task automatic t_basic();
    do_start();
    zeros(25);
    dw[0] = 16'h1234; dw[1] = 16'hABCD; dw[2] = 16'h0001;
    send_rec(3, 8'hA5, 16'h0100, 16'h0);
    repeat (3) @(negedge clk);
    chk("R10 idle", done_o, 0);
    zeros(9);
    chk("R4 nine zeros", done_o, 0);
    zeros(1);
    chk("R4 done", done_o, 1);
    chk("R4 status", status_o, 0);
    chk("R2 count", wcnt, 3);
    chk("R2 a0", wl_a[0], 15'h0100);
    chk("R2 a2", wl_a[2], 15'h0102);
    chk("R2 d0", wl_d[0], 16'h1234);
    chk("R1 d1 pad ignored", wl_d[1], 16'hABCD);
    chk("R3 d2", wl_d[2], 16'h0001);
  endtask

  task automatic t_two_then_eos();
    do_start();
    dw[0] = 16'h5555;
    send_rec(1, 8'h00, 16'h0200, 16'h0);
    zeros(9);
    dw[0] = 16'h7777; dw[1] = 16'h8888;
    send_rec(2, 8'hFF, 16'h0300, 16'h0);
    chk("R4 second rec", done_o, 0);
    chk("R4 writes", wcnt, 3);
    chk("R4 addr", wl_a[2], 15'h0301);
    zeros(2);
    end_stream();
    chk("R5 done", done_o, 1);
    chk("R5 status", status_o, 0);
  endtask

  task automatic t_bad_sum();
    int w0;
    do_start();
    dw[0] = 16'h0F0F;
    send_rec(1, 8'h11, 16'h0040, 16'h0001);
    wait_done();
    chk("R3 done", done_o, 1);
    chk("R3 status", status_o, 2);
    w0 = wcnt;
    @(negedge clk) byte_i = 8'h02; valid_i = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 ready", ready_o, 0);
    chk("R8 done hold", done_o, 1);
    chk("R8 status hold", status_o, 2);
    chk("R8 no write", wcnt, w0);
    valid_i = 1'b0;
    do_start();
    chk("R8 start clears", {done_o, status_o}, 0);
    chk("R8 ready", ready_o, 1);
  endtask

  task automatic t_eos_inside();
    do_start();
    put(8'h02);
    end_stream();
    chk("R6 pad status", status_o, 1);
    do_start();
    put(8'h02); put(8'h00); put_word(16'h0010); put(8'h12);
    end_stream();
    chk("R6 data status", status_o, 1);
    chk("R6 no write", wcnt, 0);
  endtask

  task automatic t_range();
    mem_size_i = 16'h0102;
    do_start();
    dw[0] = 16'hAAAA; dw[1] = 16'hBBBB; dw[2] = 16'hCCCC; dw[3] = 16'hDDDD;
    send_rec(4, 8'h00, 16'h0100, 16'h0);
    zeros(10);
    chk("R7 status", status_o, 0);
    chk("R7 done", done_o, 1);
    chk("R7 count", wcnt, 2);
    chk("R7 last", wl_a[1], 15'h0101);
  endtask

  task automatic t_wrap();
    mem_size_i = 16'h0010;
    do_start();
    dw[0] = 16'hFFFF; dw[1] = 16'h0002; dw[2] = 16'h4321;
    send_rec(3, 8'h00, 16'hFFFE, 16'h0);
    zeros(10);
    chk("R11 status", status_o, 0);
    chk("R7 skipped", wcnt, 1);
    chk("R11 wrap addr", wl_a[0], 15'h0000);
    chk("R11 wrap data", wl_d[0], 16'h4321);
    mem_size_i = 16'h8000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_two_then_eos();
    t_bad_sum();
    t_eos_inside();
    t_range();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule